// File: doc/BRIEF.md
# Banked Cartridge Memory Decoder

This block sits between a processor and its memories in a machine whose whole 16-bit word address space is memory mapped. The lowest quarter of the space is served by fixed internal memory. The upper three quarters form a 48K-word window into a removable cartridge. The cartridge holds 32 banks of 16K words, 512K words in all. A bank-select register, itself mapped at word address 0x00CC, picks which banks the window shows. The block drives the chip selects, the write strobes and a bank-extended cartridge address. It also steers the read data back to the processor.

Some cartridge banks are EEPROM that holds program code, so they must never be written while the machine runs. A writable mask, fixed at elaboration, marks which banks accept writes. The block drops any write aimed at a bank whose mask bit is clear.

Every pin is a plain control or data pin. The block applies no back-pressure: it accepts a request in every cycle, and each read returns exactly one cycle after it is issued. The memories behind it must have a one-cycle synchronous read.

Top module: `cart_bank_decoder`

## Requirements
- R1: When a read or write targets an address with bits [15:14] = 00, the block asserts `int_cs`, keeps `cart_cs` low, and drives `int_addr` = address bits [13:0] in the same cycle.
- R2: When a read targets an address whose bits [15:14] hold a value q of 1, 2 or 3, the block asserts `cart_cs` and keeps `int_cs` low. In the same cycle it drives `cart_addr` = {bank, address[13:0]}, with bank = (B + q - 1) mod 32, where B is the bank register.
- R3: After reset the bank register holds 0, so address 0x4000 maps to cartridge address 0x00000.
- R4: A write to 0x00CC loads write-data bits [4:0] into the bank register, and the new value is used from the next cycle on. In the cycle of that write, the block also asserts `int_cs` and `int_we` with `int_addr` = 0x00CC, so the internal copy stores the value and it reads back.
- R5: A cartridge write goes out with `cart_cs` and `cart_we` high only when bit [bank] of the writable mask is 1. Otherwise both signals stay low for that write.
- R6: One cycle after a read request, `cpu_rvalid` is high and `cpu_rdata` carries the internal or the cartridge read data. The choice follows the region of the address that was requested. In a cycle with no read request one cycle earlier, `cpu_rvalid` is low.
- R7: With neither `cpu_re` nor `cpu_we` high, both chip selects and both write strobes are low.
- R8: The bank calculation wraps modulo 32. With B = 31, addresses with bits [15:14] = 11 select bank 1.
- R9: Writes pass `cpu_wdata` unchanged to `int_wdata` and `cart_wdata`, and the internal write strobe follows `cpu_we` for every internal-region address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read request |
| cpu_rdata | output | 16 | Read data, one cycle after the request |
| cpu_rvalid | output | 1 | Read data valid |
| int_cs | output | 1 | Internal memory select |
| int_we | output | 1 | Internal memory write strobe |
| int_addr | output | 14 | Internal memory word address |
| int_wdata | output | 16 | Internal memory write data |
| int_rdata | input | 16 | Internal memory read data (one-cycle latency) |
| cart_cs | output | 1 | Cartridge select |
| cart_we | output | 1 | Cartridge write strobe |
| cart_addr | output | 19 | Bank-extended cartridge word address |
| cart_wdata | output | 16 | Cartridge write data |
| cart_rdata | input | 16 | Cartridge read data (one-cycle latency) |

## Verification
The chip selects, the write strobes, the addresses and the write data are combinational. The bench checks them a short delay after it drives the inputs, before the next rising edge. A bank-register write counts from the rising edge that ends the write cycle, so the bench checks the new mapping only on an access issued after that edge. Read data and `cpu_rvalid` arrive one edge after the request, so the bench samples them at the falling edge that follows. The bench memory models register their data on that same edge.

// File: rtl/cart_dec_pkg.sv
package cart_dec_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_INT  = 2'd1,
    RGN_CART = 2'd2
  } region_e;
endpackage

// File: rtl/cdec_bank_reg.sv
module cdec_bank_reg #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 5,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h00CC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [BANK_W-1:0] bank_q
);
  logic hit;
  assign hit = we && (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bank_q <= '0;
    else if (hit) bank_q <= wdata[BANK_W-1:0];
  end
endmodule

// File: rtl/cdec_region.sv
module cdec_region
  import cart_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 5,
  localparam int OFF_W = ADDR_W - 2
) (
  input  logic              access,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank_q,
  output region_e           region,
  output logic [BANK_W-1:0] bank_idx,
  output logic [OFF_W-1:0]  offset
);
  logic [1:0] quarter;
  assign quarter = addr[ADDR_W-1 -: 2];
  assign offset  = addr[OFF_W-1:0];

  always_comb begin
    bank_idx = bank_q + BANK_W'(quarter) - BANK_W'(1);
    if (!access)              region = RGN_NONE;
    else if (quarter == 2'b00) region = RGN_INT;
    else                      region = RGN_CART;
  end
endmodule

// File: rtl/cdec_wguard.sv
module cdec_wguard #(
  parameter int BANK_W = 5,
  localparam int NBANKS = 1 << BANK_W,
  parameter logic [NBANKS-1:0] WMASK = '0
) (
  input  logic [BANK_W-1:0] bank_idx,
  output logic              writable
);
  logic [NBANKS-1:0] mask_w;
  for (genvar i = 0; i < NBANKS; i++) begin : g_mask
    assign mask_w[i] = WMASK[i];
  end
  assign writable = mask_w[bank_idx];
endmodule

// File: rtl/cdec_rmux.sv
module cdec_rmux
  import cart_dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  region_e           region,
  input  logic [DATA_W-1:0] int_rdata,
  input  logic [DATA_W-1:0] cart_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic from_cart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid      <= 1'b0;
      from_cart_q <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) from_cart_q <= (region == RGN_CART);
    end
  end

  assign rdata = from_cart_q ? cart_rdata : int_rdata;
endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
  import cart_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BANK_W = 5,
  parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 16'h00CC,
  parameter logic [(1<<BANK_W)-1:0] WMASK = 32'h0000_FF00,
  localparam int OFF_W  = ADDR_W - 2,
  localparam int CART_W = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              int_cs,
  output logic              int_we,
  output logic [OFF_W-1:0]  int_addr,
  output logic [DATA_W-1:0] int_wdata,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              cart_cs,
  output logic              cart_we,
  output logic [CART_W-1:0] cart_addr,
  output logic [DATA_W-1:0] cart_wdata,
  input  logic [DATA_W-1:0] cart_rdata
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_idx;
  logic [OFF_W-1:0]  offset;
  logic              writable;
  logic              access;
  logic              blocked;
  region_e           region;

  assign access = cpu_re | cpu_we;

  cdec_bank_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .REG_ADDR(BANK_REG_ADDR)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata),
    .we(cpu_we), .bank_q(bank_q)
  );

  cdec_region #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_region (
    .access(access), .addr(cpu_addr), .bank_q(bank_q),
    .region(region), .bank_idx(bank_idx), .offset(offset)
  );

  cdec_wguard #(.BANK_W(BANK_W), .WMASK(WMASK)) u_guard (
    .bank_idx(bank_idx), .writable(writable)
  );

  cdec_rmux #(.DATA_W(DATA_W)) u_rmux (
    .clk(clk), .rst_n(rst_n), .re(cpu_re), .region(region),
    .int_rdata(int_rdata), .cart_rdata(cart_rdata),
    .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );

  assign blocked    = cpu_we && !writable;
  assign int_cs     = (region == RGN_INT);
  assign int_we     = int_cs && cpu_we;
  assign int_addr   = offset;
  assign int_wdata  = cpu_wdata;
  assign cart_cs    = (region == RGN_CART) && !blocked;
  assign cart_we    = cart_cs && cpu_we;
  assign cart_addr  = {bank_idx, offset};
  assign cart_wdata = cpu_wdata;
endmodule

// File: rtl/cart_bank_decoder_chk.sv
module cart_bank_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BANK_W = 5,
  parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 16'h00CC,
  parameter logic [(1<<BANK_W)-1:0] WMASK = '0,
  localparam int CART_W = BANK_W + ADDR_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_we,
  input logic              cpu_re,
  input logic              cpu_rvalid,
  input logic              int_cs,
  input logic              int_we,
  input logic              cart_cs,
  input logic              cart_we,
  input logic [CART_W-1:0] cart_addr,
  input logic [BANK_W-1:0] bank_q
);
  // R1
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_cs && cart_cs));

  // R4
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == BANK_REG_ADDR) |=> (bank_q == $past(cpu_wdata[BANK_W-1:0])));

  // R5
  write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cart_we |-> WMASK[cart_addr[CART_W-1 -: BANK_W]]);

  // R6
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_re |=> cpu_rvalid);

  // R6
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_re |=> !cpu_rvalid);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_re || cpu_we) |-> !(int_cs || cart_cs || int_we || cart_we));
endmodule

bind cart_bank_decoder cart_bank_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .BANK_REG_ADDR(BANK_REG_ADDR), .WMASK(WMASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rvalid(cpu_rvalid),
  .int_cs(int_cs), .int_we(int_we), .cart_cs(cart_cs), .cart_we(cart_we),
  .cart_addr(cart_addr), .bank_q(bank_q)
);

// File: tb/cart_bank_decoder_bench.sv
`timescale 1ns/1ps
module cart_bank_decoder_bench;
  localparam logic [31:0] MASK = 32'hF0F0_00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_re = 1'b0;
  logic [15:0] cpu_rdata;
  logic        cpu_rvalid;
  logic        int_cs, int_we, cart_cs, cart_we;
  logic [13:0] int_addr;
  logic [15:0] int_wdata, cart_wdata;
  logic [18:0] cart_addr;
  logic [15:0] int_rdata = '0;
  logic [15:0] cart_rdata = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cart_bank_decoder #(.WMASK(MASK)) u_cart_bank_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .int_cs(int_cs), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .cart_cs(cart_cs), .cart_we(cart_we),
    .cart_addr(cart_addr), .cart_wdata(cart_wdata), .cart_rdata(cart_rdata)
  );

  function automatic logic [15:0] int_pat(logic [13:0] a);
    return {2'b01, a} ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] cart_pat(logic [18:0] a);
    return a[15:0] ^ {a[18:14], 11'h2F1};
  endfunction

  // behavioural memories with one-cycle read
  always @(posedge clk) begin
    if (int_cs && !int_we)   int_rdata  <= int_pat(int_addr);
    if (cart_cs && !cart_we) cart_rdata <= cart_pat(cart_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_we = 0; cpu_re = 0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  // one access cycle; inputs driven at a falling edge
  task automatic do_read(input logic [15:0] a, input int bank);
    logic [18:0] ca;
    cpu_addr = a; cpu_re = 1; cpu_we = 0;
    #1;
    if (a[15:14] == 2'b00) begin
      chk(int_cs && !cart_cs && int_addr == a[13:0], "R1",
          {int_cs, cart_cs, int_addr}, {2'b10, a[13:0]});
    end else begin
      ca = {5'(bank), a[13:0]};
      chk(cart_cs && !int_cs && cart_addr == ca, "R2",
          {int_cs, cart_cs, cart_addr}, {2'b01, ca});
    end
    @(negedge clk);
    idle();
    #1;
    if (a[15:14] == 2'b00)
      chk(cpu_rvalid && cpu_rdata == int_pat(a[13:0]), "R6",
          {cpu_rvalid, cpu_rdata}, {1'b1, int_pat(a[13:0])});
    else
      chk(cpu_rvalid && cpu_rdata == cart_pat({5'(bank), a[13:0]}), "R6",
          {cpu_rvalid, cpu_rdata}, {1'b1, cart_pat({5'(bank), a[13:0]})});
    @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int bank);
    bit wr_ok;
    cpu_addr = a; cpu_wdata = d; cpu_we = 1; cpu_re = 0;
    #1;
    if (a[15:14] == 2'b00) begin
      chk(int_cs && int_we && !cart_cs && !cart_we && int_wdata == d &&
          int_addr == a[13:0], "R9",
          {int_cs, int_we, cart_cs, cart_we, int_wdata}, {4'b1100, d});
    end else begin
      wr_ok = MASK[bank];
      chk(cart_cs == wr_ok && cart_we == wr_ok && !int_cs && !int_we, "R5",
          {int_cs, int_we, cart_cs, cart_we}, {2'b00, wr_ok, wr_ok});
      if (wr_ok)
        chk(cart_wdata == d && cart_addr == {5'(bank), a[13:0]}, "R9",
            {cart_wdata, 13'h0, cart_addr}, {d, 13'h0, 5'(bank), a[13:0]});
    end
    @(negedge clk);
    idle();
    #1;
    chk(!cpu_rvalid, "R6", cpu_rvalid, 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R7: idle means no selects
    chk(!int_cs && !cart_cs && !int_we && !cart_we && !cpu_rvalid, "R7",
        {int_cs, cart_cs, int_we, cart_we, cpu_rvalid}, 0);
    @(negedge clk);
    // R3: reset bank is 0
    do_read(16'h4000, 0);
    do_read(16'hC123, 2);
    // R1 / R9 internal region
    do_read(16'h0000, 0);
    do_read(16'h1234, 0);
    do_read(16'h3FFF, 0);
    do_write(16'h2222, 16'hBEEF, 0);
    // sweep all banks
    for (int b = 0; b < 32; b++) begin
      cpu_addr = 16'h00CC; cpu_wdata = 16'hAB00 | 16'(b); cpu_we = 1;
      #1;
      // R4: internal copy written in the same cycle
      chk(int_cs && int_we && int_addr == 14'h00CC && int_wdata == (16'hAB00 | 16'(b)),
          "R4", {int_cs, int_we, int_addr}, {2'b11, 14'h00CC});
      @(negedge clk);
      idle();
      @(negedge clk);
      for (int q = 1; q < 4; q++) begin
        int eb;
        eb = (b + q - 1) % 32;   // R8 wrap
        do_read({2'(q), 14'(b * 97 + q * 13)}, eb);
        do_write({2'(q), 14'(b * 31 + q)}, 16'(b * 257 + q), eb);
      end
    end
    // R8: bank 31 with quarter 3 gives bank 1
    cpu_addr = 16'h00CC; cpu_wdata = 16'd31; cpu_we = 1;
    @(negedge clk);
    idle();
    @(negedge clk);
    cpu_addr = 16'hC005; cpu_re = 1;
    #1;
    chk(cart_addr == {5'd1, 14'h0005}, "R8", cart_addr, {5'd1, 14'h0005});
    @(negedge clk);
    idle();
    @(negedge clk);
    // R4: read back the internal copy
    do_read(16'h00CC, 0);
    #1;
    chk(!cpu_rvalid, "R6", cpu_rvalid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule